// File: doc/BRIEF.md
# Fractional SPI Bit-Clock Generator

This block derives the serial bit clock of an SPI controller from a fast reference clock. It does not divide by an integer; an 11-bit phase register instead gains a programmable step on every reference cycle. The upper half of the phase range is the active half of SCK. Crossing into that half gives the leading SCK edge, and wrapping past 2048 gives the trailing edge, so the SCK rate is reference × step / 2048.

Eight timing profiles are presented on a flat input bus. Each profile holds a 16-bit control word and two edge-select bits. A start pulse from the transfer sequencer names the profile to use. The block captures that profile's step, its doubling flag and its edge choices, and may clear the phase so that every transfer begins at the same point. The block then produces the SCK level, with a global polarity input setting the idle level, and two single-cycle strobes in the reference domain. The strobes tell the shift logic when to launch outgoing data and when to latch incoming data.

The controller is a two-state machine. `ST_IDLE` holds SCK at its idle level. `ST_RUN` advances the phase. There are three named transitions. *Engage* goes from `ST_IDLE` to `ST_RUN` on an accepted start. *Restart* stays in `ST_RUN` on an accepted start: it recaptures the profile and may clear the phase. *Halt* goes from `ST_RUN` to `ST_IDLE` when the enable input drops.

Top module: `spiclk_gen`

## Requirements
- R1: After reset the block is idle (`active`=0), `sck` equals `cpol`, and both strobes are 0.
- R2: A start pulse with `run_en`=1 and a valid profile number enters or restarts `ST_RUN`, with `active`=1 from the next cycle. The chosen profile is captured at that edge, and later changes on the profile inputs have no effect until the next start.
- R3: A start pulse is ignored while `run_en`=0, or when `start_prof` is not below the number of profiles (8). The block stays idle.
- R4: In `ST_RUN` the phase grows by the effective step every cycle, modulo 2048, starting from the cycle after the start. `sck` = `cpol` XOR (phase ≥ 1024). The leading SCK edge happens when the phase enters [1024,2048), and the trailing edge happens when it wraps past 2048.
- R5: The step is bits [13:0] of the profile word. Bit 14 doubles it. The doubled or plain result is clamped to 1024 (one SCK period per two reference cycles), and a step of 0 freezes SCK.
- R6: On an accepted start, profile word bit 15 = 1 clears the phase to 0. With bit 15 = 0 the phase keeps its value, so `sck` resumes at the level that value implies.
- R7: `latch_stb` pulses for one cycle in the same cycle that `sck` first shows a new level. It pulses on rising SCK when profile edge bit 0 = 1 and on falling SCK otherwise. `launch_stb` follows the same rule using edge bit 1. Neither strobe pulses while idle.
- R8: With `run_en`=0 in `ST_RUN` the block halts: from the next cycle `active`=0, `sck`=`cpol`, and no strobe pulses. The phase is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Clock enable; low halts generation |
| start | input | 1 | One-cycle transfer start from the sequencer |
| start_prof | input | 4 | Profile number carried by the start command |
| cpol | input | 1 | SCK idle level |
| prof_word | input | 128 | Eight 16-bit profile words, profile n at bits [16n+15:16n] |
| prof_edge | input | 16 | Eight 2-bit edge selects, profile n at bits [2n+1:2n] |
| sck | output | 1 | Generated SPI clock level |
| launch_stb | output | 1 | One-cycle pulse at the launch edge |
| latch_stb | output | 1 | One-cycle pulse at the latch edge |
| active | output | 1 | High while in ST_RUN |

## Verification
A wrong phase value or a mis-captured step shows as a wrong strobe count and a wrong SCK level within the counted window of each transfer. Runs with the step at 256 show the error within four reference cycles. A stuck state register shows on `active` and `sck` one cycle after a start or a halt. A phase that is cleared when it should be kept, or kept when it should be cleared, changes `sck` in the very cycle after the start.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } clk_state_t;

    // Control word layout (16 bits)
    localparam int ROL_BIT  = 15;   // clear phase on accepted start
    localparam int DBL_BIT  = 14;   // double the step
    localparam int STEP_FW  = 14;   // step field width, bits [13:0]

    // Edge-select pair per profile
    localparam int LAT_RISE_BIT = 0;
    localparam int LAU_RISE_BIT = 1;

endpackage

// File: rtl/spiclk_prof_sel.sv
module spiclk_prof_sel
    import spiclk_pkg::*;
#(
    parameter int NUM_PROF = 8,
    parameter int WORD_W   = 16,
    parameter int SEL_W    = 4,
    parameter int PHASE_W  = 11
) (
    input  logic [NUM_PROF*WORD_W-1:0] prof_word,
    input  logic [NUM_PROF*2-1:0]      prof_edge,
    input  logic [SEL_W-1:0]           sel,
    output logic                       sel_ok,
    output logic [PHASE_W-1:0]         eff_step,
    output logic                       sel_rol,
    output logic                       sel_lat_rise,
    output logic                       sel_lau_rise
);
    localparam int IDX_W = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;
    localparam int HALF  = 1 << (PHASE_W - 1);
    localparam int SC_W  = STEP_FW + 1;

    logic [WORD_W-1:0] words [NUM_PROF];
    logic [1:0]        edges [NUM_PROF];

    for (genvar g = 0; g < NUM_PROF; g++) begin : g_unpack
        assign words[g] = prof_word[g*WORD_W +: WORD_W];
        assign edges[g] = prof_edge[g*2 +: 2];
    end

    logic [WORD_W-1:0]  w;
    logic [1:0]         e;
    logic [STEP_FW-1:0] raw;
    logic [SC_W-1:0]    scaled;

    always_comb begin
        sel_ok = (32'(sel) < NUM_PROF);
        w      = '0;
        e      = '0;
        if (sel_ok) begin
            w = words[sel[IDX_W-1:0]];
            e = edges[sel[IDX_W-1:0]];
        end
        raw    = w[STEP_FW-1:0];
        scaled = w[DBL_BIT] ? {raw, 1'b0} : {1'b0, raw};
        if (scaled > SC_W'(HALF))
            eff_step = PHASE_W'(HALF);
        else
            eff_step = scaled[PHASE_W-1:0];
        sel_rol      = w[ROL_BIT];
        sel_lat_rise = e[LAT_RISE_BIT];
        sel_lau_rise = e[LAU_RISE_BIT];
    end

endmodule

// File: rtl/spiclk_phase_acc.sv
module spiclk_phase_acc #(
    parameter int PHASE_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               clr,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase,
    output logic               ev_lead,
    output logic               ev_trail
);
    localparam int HALF = 1 << (PHASE_W - 1);

    logic [PHASE_W:0] sum;

    always_comb begin
        sum      = {1'b0, phase} + {1'b0, step};
        ev_trail = adv && sum[PHASE_W];
        ev_lead  = adv && !phase[PHASE_W-1] && sum[PHASE_W-1] && !sum[PHASE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (clr)
            phase <= '0;
        else if (adv)
            phase <= sum[PHASE_W-1:0];
    end

    // R5
    step_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(step) <= HALF);

    // R4
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_lead && ev_trail));

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter int NUM_PROF = 8,
    parameter int WORD_W   = 16,
    parameter int SEL_W    = 4,
    parameter int PHASE_W  = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_en,
    input  logic                       start,
    input  logic [SEL_W-1:0]           start_prof,
    input  logic                       cpol,
    input  logic [NUM_PROF*WORD_W-1:0] prof_word,
    input  logic [NUM_PROF*2-1:0]      prof_edge,
    output logic                       sck,
    output logic                       launch_stb,
    output logic                       latch_stb,
    output logic                       active
);
    clk_state_t state, state_nx;

    logic               sel_ok, sel_rol, sel_lat_rise, sel_lau_rise;
    logic [PHASE_W-1:0] sel_step;
    logic [PHASE_W-1:0] cur_step;
    logic               cur_lat_rise, cur_lau_rise;
    logic [PHASE_W-1:0] phase;
    logic               ev_lead, ev_trail;
    logic               start_acc, adv, clr;
    logic               ev_rise, ev_fall;

    spiclk_prof_sel #(
        .NUM_PROF(NUM_PROF), .WORD_W(WORD_W), .SEL_W(SEL_W), .PHASE_W(PHASE_W)
    ) u_sel (
        .prof_word    (prof_word),
        .prof_edge    (prof_edge),
        .sel          (start_prof),
        .sel_ok       (sel_ok),
        .eff_step     (sel_step),
        .sel_rol      (sel_rol),
        .sel_lat_rise (sel_lat_rise),
        .sel_lau_rise (sel_lau_rise)
    );

    assign start_acc = start && run_en && sel_ok;
    assign clr       = start_acc && sel_rol;
    assign adv       = (state == ST_RUN) && run_en && !start_acc;

    spiclk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .clr      (clr),
        .step     (cur_step),
        .phase    (phase),
        .ev_lead  (ev_lead),
        .ev_trail (ev_trail)
    );

    // Next-state logic: engage, restart, halt
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_acc) state_nx = ST_RUN;
            ST_RUN:  if (!run_en)   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Profile capture on accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_step     <= '0;
            cur_lat_rise <= 1'b0;
            cur_lau_rise <= 1'b0;
        end else if (start_acc) begin
            cur_step     <= sel_step;
            cur_lat_rise <= sel_lat_rise;
            cur_lau_rise <= sel_lau_rise;
        end
    end

    // Output process: strobes registered with the phase update
    always_comb begin
        ev_rise = cpol ? ev_trail : ev_lead;
        ev_fall = cpol ? ev_lead  : ev_trail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_stb  <= 1'b0;
            launch_stb <= 1'b0;
        end else begin
            latch_stb  <= cur_lat_rise ? ev_rise : ev_fall;
            launch_stb <= cur_lau_rise ? ev_rise : ev_fall;
        end
    end

    assign active = (state == ST_RUN);
    assign sck    = cpol ^ (active && phase[PHASE_W-1]);

    // R7
    stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!launch_stb && !latch_stb));

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !active);

    // R6
    rol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && sel_rol) |=> (phase == '0));

    // R4
    sck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(start_acc) && $stable(cpol) && !$stable(sck))
        |-> $past(ev_lead || ev_trail));

endmodule

// File: tb/spiclk_gen_tb.sv
module spiclk_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         run_en;
    logic         start;
    logic [3:0]   start_prof;
    logic         cpol;
    logic [127:0] prof_word;
    logic [15:0]  prof_edge;
    logic         sck, launch_stb, latch_stb, active;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    spiclk_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .start      (start),
        .start_prof (start_prof),
        .cpol       (cpol),
        .prof_word  (prof_word),
        .prof_edge  (prof_edge),
        .sck        (sck),
        .launch_stb (launch_stb),
        .latch_stb  (latch_stb),
        .active     (active)
    );

    // {word[15:0], edge[1:0], cpol, cycles[7:0], leads[7:0], wraps[7:0], end_upper}
    localparam logic [43:0] VEC [7] = '{
        {16'h8100, 2'b01, 1'b0, 8'd32, 8'd4, 8'd4, 1'b0},
        {16'h8400, 2'b10, 1'b1, 8'd10, 8'd5, 8'd5, 1'b0},
        {16'hC080, 2'b11, 1'b0, 8'd12, 8'd2, 8'd1, 1'b1},
        {16'h9388, 2'b00, 1'b1, 8'd7,  8'd4, 8'd3, 1'b1},
        {16'h8258, 2'b01, 1'b1, 8'd10, 8'd3, 8'd2, 1'b1},
        {16'h8000, 2'b01, 1'b0, 8'd10, 8'd0, 8'd0, 1'b0},
        {16'hC2BC, 2'b10, 1'b0, 8'd6,  8'd3, 8'd3, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int sel);
        start      = 1'b1;
        start_prof = 4'(sel);
        @(negedge clk);
        start      = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; start = 1'b0; start_prof = '0;
        cpol = 1'b1; prof_word = '0; prof_edge = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active", int'(active), 0);
        chk("R1 sck idle", int'(sck), 1);
        chk("R1 strobes", int'(launch_stb | latch_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R4 R5 R7 counts and final levels
        for (int i = 0; i < 7; i++) begin
            logic [43:0] v;
            int n, f, w, exp_rise, exp_fall, lat_n, lau_n;
            v = VEC[i];
            prof_word[i*16 +: 16] = v[43:28];
            prof_edge[i*2 +: 2]   = v[27:26];
            cpol   = v[25];
            run_en = 1'b0;
            @(negedge clk);
            run_en = 1'b1;
            do_start(i);
            chk("R2 engaged", int'(active), 1);
            n = int'(v[24:17]); f = int'(v[16:9]); w = int'(v[8:1]);
            exp_rise = v[25] ? w : f;
            exp_fall = v[25] ? f : w;
            lat_n = 0; lau_n = 0;
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                if (latch_stb)  lat_n++;
                if (launch_stb) lau_n++;
            end
            chk("R7 latch count", lat_n, v[26] ? exp_rise : exp_fall);
            chk("R7 launch count", lau_n, v[27] ? exp_rise : exp_fall);
            chk("R4 R5 end sck", int'(sck), int'(v[25] ^ v[0]));
        end
        run_en = 1'b0;
        @(negedge clk);

        // R3: start while disabled
        cpol = 1'b0;
        do_start(0);
        chk("R3 start with run_en low", int'(active), 0);
        chk("R3 sck idle", int'(sck), 0);
        // R3: profile number out of range
        run_en = 1'b1;
        do_start(9);
        chk("R3 profile 9 ignored", int'(active), 0);
        do_start(8);
        chk("R3 profile 8 ignored", int'(active), 0);

        // R6: phase kept when bit 15 is clear
        prof_word[7*16 +: 16] = 16'h0100;
        prof_edge[7*2 +: 2]   = 2'b01;
        do_start(0);
        repeat (6) @(negedge clk);
        chk("R4 sck upper half", int'(sck), 1);
        run_en = 1'b0;
        @(negedge clk);
        chk("R8 halt active", int'(active), 0);
        chk("R8 halt sck", int'(sck), 0);
        run_en = 1'b1;
        do_start(7);
        chk("R6 phase kept sck", int'(sck), 1);
        @(negedge clk);
        chk("R6 still upper", int'(sck), 1);
        @(negedge clk);
        chk("R4 wrap sck", int'(sck), 0);
        chk("R7 launch on falling", int'(launch_stb), 1);
        chk("R7 no latch on falling", int'(latch_stb), 0);

        // R6: restart with clear
        repeat (5) @(negedge clk);
        chk("R4 sck before restart", int'(sck), 1);
        do_start(0);
        chk("R6 cleared sck", int'(sck), 0);
        chk("R2 restart active", int'(active), 1);

        // R2: profile change after capture has no effect
        prof_word[0 +: 16] = 16'h8400;
        @(negedge clk);
        chk("R2 old step kept", int'(sck), 0);
        repeat (3) @(negedge clk);
        chk("R2 old step lead", int'(sck), 1);

        // R8: halt with polarity high
        cpol   = 1'b1;
        run_en = 1'b0;
        @(negedge clk);
        chk("R8 halted", int'(active), 0);
        chk("R8 sck idle high", int'(sck), 1);
        chk("R8 no strobes", int'(launch_stb | latch_stb), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule